// File: doc/BRIEF.md
# Real-Time Clock with Match Alarm

This peripheral keeps a running seconds count and raises an interrupt when that count reaches a programmed match value. A one-cycle `tick` strobe, produced outside the block once per second, advances the counter. Software talks to the block over a simple register bus. Writes land on the clock edge. Reads are combinational, so read data is valid in the same cycle the offset is presented. Offsets are byte addresses and must be word-aligned.

Software sets the time by writing the load register. The counter then continues from the written value. Software programs an alarm instant through the match register and gates the interrupt with a one-bit enable. A sticky raw flag records that the alarm happened. Software acknowledges the alarm by writing anything to the clear register.

The match test is a plain equality between the count and the match value. Because the counter is free-running and wraps, an alarm set "behind" the current count fires after the counter wraps. The count is re-evaluated whenever it or the match value changes.

Top module: `rtc_alarm`

## Requirements
- R1: A write to offset 0x08 sets the count to the written value (truncated to the counter width), and later ticks count on from that value. If a tick and a load land in the same cycle, the load wins. A read of 0x08 returns the current count.
- R2: Each cycle with `tick` high adds one to the count, which wraps from its all-ones value to zero. Offset 0x00 reads the count, zero-extended.
- R3: A write to offset 0x04 stores the match value, which reads back at 0x04. The compare is redone against the current count, and if they are equal the raw flag is set one cycle after the write.
- R4: Whenever a tick, load or match write leaves the count equal to the match value, the raw flag is set one cycle later. This includes alarms reached only after the counter wraps, so the number of ticks from a load L to an alarm at match M is (M - L) modulo 2^width.
- R5: A write to offset 0x10 sets the interrupt enable from data bit 0 and ignores all other bits. Reading 0x10 returns the enable in bit 0.
- R6: Any write to offset 0x1C clears the raw flag whatever the data. An alarm becoming due in the same cycle as the clear takes priority, so the flag stays set.
- R7: The raw flag, read at offset 0x14 bit 0, stays set until it is cleared through offset 0x1C.
- R8: The `irq` output and offset 0x18 bit 0 both equal the raw flag AND the enable.
- R9: Writes to offsets 0x00, 0x14 or 0x18 change no state. Each one drives `errFlag` high for exactly the cycle after the write.
- R10: Writes to offset 0x0C have no effect, and that offset reads zero. Reads of misaligned offsets, and of offsets at 0x20 and above, return zero.
- R11: A synchronous active-high `rst` clears the count, the match value, the enable, the raw flag and `errFlag`. Right after reset, no alarm is raised even though the count and the match value are equal.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| tick | input | 1 | Once-per-second count strobe, one cycle wide |
| busSel | input | 1 | Bus access in this cycle |
| busWr | input | 1 | 1 = write, 0 = read |
| busAddr | input | ADDR_W | Byte offset of the register |
| busWdata | input | DATA_W | Write data |
| busRdata | output | DATA_W | Read data, combinational from the offset |
| irq | output | 1 | Level interrupt: raw flag AND enable |
| errFlag | output | 1 | One-cycle pulse after a write to a read-only register |

## Verification
The bench builds the block with an 8-bit counter (`CNT_W = 8`) and keeps the 32-bit bus and 6-bit offset. With this setting a full counter wrap costs only 256 ticks. The bench sweeps an 8 by 8 grid of load and match values, including equal pairs and pairs that must wrap. For each pair it counts the ticks to the alarm and compares that number with (M - L) mod 256. The narrow counter also makes truncation of wide load writes and the all-ones-to-zero wrap directly observable.

// File: rtl/rtc_alarm_pkg.sv
package rtc_alarm_pkg;

  // Word index of each register (byte offset >> 2).
  typedef enum logic [2:0] {
    REG_COUNT = 3'd0,
    REG_MATCH = 3'd1,
    REG_LOAD  = 3'd2,
    REG_CTRL  = 3'd3,
    REG_MASK  = 3'd4,
    REG_RAW   = 3'd5,
    REG_MIS   = 3'd6,
    REG_CLEAR = 3'd7
  } rtcReg_e;

  // Write strobes from the control path to the datapath.
  typedef struct packed {
    logic loadWr;
    logic matchWr;
    logic maskWr;
    logic clearWr;
    logic roWr;
  } rtcStrobes_t;

endpackage

// File: rtl/rtc_alarm_ctrl.sv
module rtc_alarm_ctrl
  import rtc_alarm_pkg::*;
#(
  parameter int ADDR_W = 6
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 busSel,
  input  logic                 busWr,
  input  logic [ADDR_W-1:0]    busAddr,
  output rtcStrobes_t          strobes,
  output rtcReg_e              regIdx,
  output logic                 regMapped,
  output logic                 errFlag
);

  localparam int IDX_LSB = 2;
  localparam int IDX_W   = 3;
  localparam int MAP_TOP = IDX_LSB + IDX_W;

  logic wrEn;
  logic upperZero;

  // Address bits above the map window must be zero, and the low two bits too.
  assign upperZero = ((busAddr >> MAP_TOP) == '0);
  assign regMapped = upperZero && (busAddr[IDX_LSB-1:0] == '0);
  assign regIdx    = rtcReg_e'(busAddr[MAP_TOP-1:IDX_LSB]);
  assign wrEn      = busSel && busWr && regMapped;

  always_comb begin
    strobes = '0;
    if (wrEn) begin
      unique case (regIdx)
        REG_LOAD:                   strobes.loadWr  = 1'b1;
        REG_MATCH:                  strobes.matchWr = 1'b1;
        REG_MASK:                   strobes.maskWr  = 1'b1;
        REG_CLEAR:                  strobes.clearWr = 1'b1;
        REG_COUNT, REG_RAW, REG_MIS: strobes.roWr   = 1'b1;
        default:                    strobes = '0;  // control: no effect
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) errFlag <= 1'b0;
    else     errFlag <= strobes.roWr;
  end

  // R9: an error pulse follows a bus write to a read-only offset
  p_err_cause_r9: assert property (@(posedge clk) disable iff (rst)
    errFlag |-> $past(busSel && busWr && regMapped &&
                      (busAddr[MAP_TOP-1:IDX_LSB] == 3'd0 ||
                       busAddr[MAP_TOP-1:IDX_LSB] == 3'd5 ||
                       busAddr[MAP_TOP-1:IDX_LSB] == 3'd6)));

  // R10: at most one register is written per cycle
  p_one_strobe_r10: assert property (@(posedge clk) disable iff (rst)
    $onehot0(strobes));

endmodule

// File: rtl/rtc_alarm_dp.sv
module rtc_alarm_dp
  import rtc_alarm_pkg::*;
#(
  parameter int CNT_W  = 32,
  parameter int DATA_W = 32
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               tick,
  input  rtcStrobes_t        strobes,
  input  logic [DATA_W-1:0]  wdata,
  input  rtcReg_e            regIdx,
  input  logic               regMapped,
  output logic [DATA_W-1:0]  rdata,
  output logic               irq
);

  logic [CNT_W-1:0] countQ;
  logic [CNT_W-1:0] matchQ;
  logic             maskQ;
  logic             rawQ;
  logic             evalQ;
  logic             hit;
  logic             setNow;
  logic [CNT_W-1:0] wrTrunc;
  logic [CNT_W-1:0] toGo;

  assign wrTrunc = wdata[CNT_W-1:0];

  // Wrap-safe distance to the alarm; zero means due.
  assign toGo   = matchQ - countQ;
  assign hit    = (toGo == '0);
  assign setNow = evalQ && hit;

  always_ff @(posedge clk) begin
    if (rst) begin
      countQ <= '0;
    end else if (strobes.loadWr) begin
      countQ <= wrTrunc;
    end else if (tick) begin
      countQ <= countQ + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      matchQ <= '0;
      maskQ  <= 1'b0;
      evalQ  <= 1'b0;
    end else begin
      if (strobes.matchWr) matchQ <= wrTrunc;
      if (strobes.maskWr)  maskQ  <= wdata[0];
      evalQ <= tick || strobes.loadWr || strobes.matchWr;
    end
  end

  always_ff @(posedge clk) begin
    if (rst)                  rawQ <= 1'b0;
    else if (setNow)          rawQ <= 1'b1;
    else if (strobes.clearWr) rawQ <= 1'b0;
  end

  assign irq = rawQ & maskQ;

  always_comb begin
    rdata = '0;
    if (regMapped) begin
      unique case (regIdx)
        REG_COUNT, REG_LOAD: rdata = DATA_W'(countQ);
        REG_MATCH:           rdata = DATA_W'(matchQ);
        REG_MASK:            rdata = DATA_W'(maskQ);
        REG_RAW:             rdata = DATA_W'(rawQ);
        REG_MIS:             rdata = DATA_W'(irq);
        default:             rdata = '0;
      endcase
    end
  end

  // R1: a load sets the count on the next cycle
  p_load_takes_r1: assert property (@(posedge clk) disable iff (rst)
    strobes.loadWr |=> countQ == $past(wrTrunc));

  // R2: a tick without load advances the count by one
  p_tick_inc_r2: assert property (@(posedge clk) disable iff (rst)
    (tick && !strobes.loadWr) |=> countQ == $past(countQ) + 1'b1);

  // R4: a due alarm sets the raw flag
  p_alarm_sets_r4: assert property (@(posedge clk) disable iff (rst)
    setNow |=> rawQ);

  // R7: the raw flag only falls through a clear write
  p_raw_sticky_r7: assert property (@(posedge clk) disable iff (rst)
    (rawQ && !strobes.clearWr) |=> rawQ);

  // R6: a clear with no alarm due drops the flag
  p_clear_r6: assert property (@(posedge clk) disable iff (rst)
    (strobes.clearWr && !setNow) |=> !rawQ);

  // R8: no interrupt while disabled
  p_irq_gated_r8: assert property (@(posedge clk) disable iff (rst)
    !maskQ |-> !irq);

endmodule

// File: rtl/rtc_alarm.sv
module rtc_alarm
  import rtc_alarm_pkg::*;
#(
  parameter int CNT_W  = 32,
  parameter int DATA_W = 32,
  parameter int ADDR_W = 6
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               tick,
  input  logic               busSel,
  input  logic               busWr,
  input  logic [ADDR_W-1:0]  busAddr,
  input  logic [DATA_W-1:0]  busWdata,
  output logic [DATA_W-1:0]  busRdata,
  output logic               irq,
  output logic               errFlag
);

  rtcStrobes_t strobes;
  rtcReg_e     regIdx;
  logic        regMapped;

  rtc_alarm_ctrl #(.ADDR_W(ADDR_W)) ctrl_i (
    .clk       (clk),
    .rst       (rst),
    .busSel    (busSel),
    .busWr     (busWr),
    .busAddr   (busAddr),
    .strobes   (strobes),
    .regIdx    (regIdx),
    .regMapped (regMapped),
    .errFlag   (errFlag)
  );

  rtc_alarm_dp #(.CNT_W(CNT_W), .DATA_W(DATA_W)) dp_i (
    .clk       (clk),
    .rst       (rst),
    .tick      (tick),
    .strobes   (strobes),
    .wdata     (busWdata),
    .regIdx    (regIdx),
    .regMapped (regMapped),
    .rdata     (busRdata),
    .irq       (irq)
  );

  // R11: outputs are quiet in the cycle after reset
  p_reset_quiet_r11: assert property (@(posedge clk)
    $past(rst) |-> (!irq && !errFlag));

endmodule

// File: tb/rtc_alarm_tb_top.sv
`timescale 1ns/1ps
module rtc_alarm_tb_top;

  localparam int CNT_W  = 8;
  localparam int DATA_W = 32;
  localparam int ADDR_W = 6;
  localparam int MODV   = 1 << CNT_W;

  localparam logic [ADDR_W-1:0] A_CNT = 6'h00, A_MATCH = 6'h04, A_LOAD = 6'h08,
                                A_CTRL = 6'h0C, A_MASK = 6'h10, A_RAW = 6'h14,
                                A_MIS = 6'h18, A_CLR = 6'h1C;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic tick = 1'b0;
  logic busSel = 1'b0;
  logic busWr = 1'b0;
  logic [ADDR_W-1:0] busAddr = '0;
  logic [DATA_W-1:0] busWdata = '0;
  logic [DATA_W-1:0] busRdata;
  logic irq, errFlag;

  int vecs = 0;
  int fails = 0;
  int cycles = 0;

  always #2.5 clk = ~clk;

  rtc_alarm #(.CNT_W(CNT_W), .DATA_W(DATA_W), .ADDR_W(ADDR_W)) dut_i (
    .clk(clk), .rst(rst), .tick(tick), .busSel(busSel), .busWr(busWr),
    .busAddr(busAddr), .busWdata(busWdata), .busRdata(busRdata),
    .irq(irq), .errFlag(errFlag)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    vecs++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [ADDR_W-1:0] a, input logic [31:0] d);
    @(negedge clk);
    busSel = 1'b1; busWr = 1'b1; busAddr = a; busWdata = d;
    @(negedge clk);
    busSel = 1'b0; busWr = 1'b0;
  endtask

  task automatic rd(input logic [ADDR_W-1:0] a, output logic [31:0] d);
    @(negedge clk);
    busSel = 1'b1; busWr = 1'b0; busAddr = a;
    #1 d = busRdata;
    busSel = 1'b0;
  endtask

  task automatic doTick();
    @(negedge clk); tick = 1'b1;
    @(negedge clk); tick = 1'b0;
    @(negedge clk);
  endtask

  // Load L, drop any stray flag, then program match M.
  task automatic setup(input int L, input int M);
    wr(A_LOAD, L);
    @(negedge clk);
    wr(A_CLR, 32'h0);
    wr(A_MATCH, M);
    @(negedge clk);
  endtask

  initial begin
    while (cycles < 150000) begin
      @(posedge clk);
      cycles++;
    end
    fails++;
    $display("FAIL watchdog act=%0d exp=done", cycles);
    $display("== %0d vectors applied, %0d miscompares ==", vecs, fails);
    $finish;
  end

  initial begin
    logic [31:0] d;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    @(negedge clk);

    // R11: reset state, no alarm although count == match == 0
    rd(A_CNT, d);   chk("R11 count", d, 0);
    rd(A_MATCH, d); chk("R11 match", d, 0);
    rd(A_MASK, d);  chk("R11 mask", d, 0);
    rd(A_RAW, d);   chk("R11 raw", d, 0);
    chk("R11 irq", irq, 0);
    chk("R11 err", errFlag, 0);

    // R10: control write ignored, unmapped reads zero
    wr(A_CTRL, 32'hFFFF_FFFF);
    rd(A_CTRL, d); chk("R10 ctrl read", d, 0);
    rd(A_MASK, d); chk("R10 ctrl no effect", d, 0);
    rd(A_CNT, d);  chk("R10 ctrl no effect count", d, 0);
    wr(A_LOAD, 32'h5A);
    rd(6'h20, d);  chk("R10 high offset", d, 0);
    rd(6'h02, d);  chk("R10 misaligned", d, 0);

    // R1: truncation and load readback
    wr(A_LOAD, 32'h1234_56C3);
    rd(A_LOAD, d); chk("R1 load readback", d, 32'hC3);
    rd(A_CNT, d);  chk("R1 load count", d, 32'hC3);

    // R5: only bit 0 of a mask write matters
    wr(A_MASK, 32'hFFFF_FFFE);
    rd(A_MASK, d); chk("R5 mask bit0 clear", d, 0);
    wr(A_MASK, 32'h0000_0003);
    rd(A_MASK, d); chk("R5 mask bit0 set", d, 1);

    // R9: read-only writes pulse errFlag and change nothing
    wr(A_CNT, 32'h77);
    chk("R9 err pulse", errFlag, 1);
    @(negedge clk);
    chk("R9 err one cycle", errFlag, 0);
    rd(A_CNT, d); chk("R9 count unchanged", d, 32'hC3);
    wr(A_RAW, 32'h1);
    chk("R9 err raw", errFlag, 1);
    rd(A_RAW, d); chk("R9 raw unchanged", d, 0);
    wr(A_MIS, 32'h1);
    chk("R9 err mis", errFlag, 1);
    wr(A_MASK, 32'h1);
    chk("R9 no err on rw", errFlag, 0);

    // R1: load wins over simultaneous tick
    @(negedge clk);
    tick = 1'b1; busSel = 1'b1; busWr = 1'b1; busAddr = A_LOAD; busWdata = 100;
    @(negedge clk);
    tick = 1'b0; busSel = 1'b0; busWr = 1'b0;
    rd(A_CNT, d); chk("R1 load beats tick", d, 100);
    doTick();
    rd(A_CNT, d); chk("R1 ticks continue", d, 101);

    // R2: wrap from all-ones to zero
    setup(255, 10);
    doTick();
    rd(A_CNT, d); chk("R2 wrap", d, 0);

    // R3: match write equal to count raises raw one cycle later
    setup(40, 41);
    wr(A_MATCH, 40);
    chk("R3 not yet", irq, 0);
    @(negedge clk);
    rd(A_RAW, d); chk("R3 match write alarm", d, 1);

    // R6/R7: sticky until clear, clear with any data
    doTick();
    rd(A_RAW, d); chk("R7 sticky", d, 1);
    wr(A_CLR, 32'h0);
    rd(A_RAW, d); chk("R6 clear any data", d, 0);

    // R6: alarm due in the same cycle as a clear wins
    setup(10, 11);
    @(negedge clk); tick = 1'b1;
    @(negedge clk); tick = 1'b0;
    busSel = 1'b1; busWr = 1'b1; busAddr = A_CLR; busWdata = 32'h1;
    @(negedge clk);
    busSel = 1'b0; busWr = 1'b0;
    rd(A_RAW, d); chk("R6 set beats clear", d, 1);

    // R4/R8: sweep of load/match pairs
    for (int li = 0; li < 8; li++) begin
      for (int mi = 0; mi < 8; mi++) begin
        int L, M, expT, got;
        logic mask;
        L = (li * 37 + 5) % MODV;
        M = (mi == li) ? L : (mi * 53 + 250) % MODV;
        expT = (M - L + MODV) % MODV;
        mask = logic'((li + mi) % 2);
        wr(A_MASK, {31'h0, mask});
        setup(L, M);
        got = 0;
        rd(A_RAW, d);
        while (d[0] == 1'b0 && got < MODV + 2) begin
          doTick();
          got++;
          rd(A_RAW, d);
        end
        chk($sformatf("R4 ticks L=%0d M=%0d", L, M), got, expT);
        rd(A_CNT, d); chk("R4 count at alarm", d, M);
        chk("R8 irq", irq, mask);
        rd(A_MIS, d); chk("R8 masked status", d, mask);
        wr(A_CLR, 32'h0);
        chk("R8 irq after clear", irq, 0);
      end
    end

    $display("== %0d vectors applied, %0d miscompares ==", vecs, fails);
    $finish;
  end

endmodule